// File: doc/BRIEF.md
# Chained Descriptor Loader for a DMA Channel

This block walks a chain of transfer records kept in memory so that a DMA channel can run transaction after transaction with no software in between. Software hands the block the address of the first record and pulses a trigger. The block then reads the eight-word record through a single-outstanding read port. It loads the record into the channel's working registers and raises a start pulse for the data mover. It then keeps the running source and destination addresses and the remaining length up to date as the mover reports each beat.

When a transaction drains, the block checks the record's control word. If the stop flag is clear, it follows the record's link word to the next record. Records normally form a ring, with the last one pointing back to the first, so the walk can go on for as long as needed. If the stop flag is set, the block emits a one-cycle list-completion pulse and goes idle. The source address has a wrap comparator: a beat taken at the programmed wrap address moves the source pointer to the programmed wrap target instead of the next word. A read response flagged as an error abandons the chain.

Top module: `desc_chain_loader`

## Requirements
- R1: After reset the loader is idle: `rd_req`, `xfer_active`, `xfer_start`, `list_done` and `load_err` are 0, and `xfer_src`, `xfer_dst` and `xfer_remaining` are 0.
- R2: A `start` pulse while idle captures `list_ptr` and reads the record's eight words at `list_ptr + 4*k` for k = 0..7, in order. Only one request is outstanding at a time, and `rd_addr` is held until `rd_ack`.
- R3: Record word layout: 0 source, 1 destination, 2 length (low `LEN_W` bits), 3 wrap address, 4 wrap target, 5 control, 6 link, 7 reserved. One cycle after the eighth response, `xfer_start` pulses for one cycle with `xfer_active` high, and `xfer_src`, `xfer_dst` and `xfer_remaining` hold the record's values.
- R4: Each cycle with `xfer_active`, `beat` and a nonzero `xfer_remaining` adds 4 to `xfer_dst` and takes 1 from `xfer_remaining`.
- R5: On such a beat, if `xfer_src` equals the wrap address, the next `xfer_src` is the wrap target. Otherwise `xfer_src` increases by 4.
- R6: When `xfer_remaining` reaches 0 and control bit 0 (stop) is clear, the loader fetches the record at the link address and starts it. A ring of records is walked repeatedly.
- R7: When `xfer_remaining` reaches 0 and the stop bit is set, `list_done` pulses for exactly one cycle. At that point `xfer_active` and `rd_req` are 0, and no further reads are issued.
- R8: A response with `rd_err` set ends the fetch: `load_err` rises, `rd_req` drops, no transaction starts and the loader is idle. `load_err` stays set until the next accepted `start` clears it.
- R9: `start` is ignored while a record is being fetched or a transaction is running.
- R10: A record with length 0 completes without any beat and is handled like any other completed record.
- R11: `beat` has no effect while no transaction is active: `xfer_src`, `xfer_dst` and `xfer_remaining` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Trigger pulse; starts the chain when idle |
| list_ptr | input | AW | Byte address of the first record |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Byte address of the word being read |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DW | Read response data |
| rd_err | input | 1 | Read response carries an error |
| beat | input | 1 | Data mover moved one word at the current addresses |
| xfer_src | output | AW | Running source address |
| xfer_dst | output | AW | Running destination address |
| xfer_remaining | output | LEN_W | Words left in the current transaction |
| xfer_active | output | 1 | A transaction is running |
| xfer_start | output | 1 | One-cycle pulse when a transaction starts |
| list_done | output | 1 | One-cycle pulse when a stop-flagged record completes |
| load_err | output | 1 | Sticky read-error flag |

## Verification
The bench targets the wrap comparator in several positions: at the first address, in the middle, never reached, and with a two-address ping-pong. A design that compared after incrementing, or that wrapped the destination too, would end on wrong addresses. A two-record ring is walked back to its head and then stopped by editing a control word in memory. A loader that trusted a stale link or latched the stop flag early would start the wrong record or finish too soon.

Triggers are pulsed during fetch and during a transaction, where a loader that re-armed would issue extra reads or restart. An errored read in the middle of a record must stop the reads at exactly four, and a zero-length record must finish without beats rather than underflow its counter.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2,
        ST_NEXT  = 2'd3
    } dcl_state_e;

    localparam int REC_WORDS = 8;
    localparam int REC_IDX_W = $clog2(REC_WORDS);

    // word positions inside one record (fetch order)
    localparam logic [REC_IDX_W-1:0] WI_SRC  = 3'd0;
    localparam logic [REC_IDX_W-1:0] WI_DST  = 3'd1;
    localparam logic [REC_IDX_W-1:0] WI_LEN  = 3'd2;
    localparam logic [REC_IDX_W-1:0] WI_WRAP = 3'd3;
    localparam logic [REC_IDX_W-1:0] WI_WTO  = 3'd4;
    localparam logic [REC_IDX_W-1:0] WI_CTRL = 3'd5;
    localparam logic [REC_IDX_W-1:0] WI_LINK = 3'd6;

    localparam int CTRL_STOP_BIT = 0;

endpackage

// File: rtl/dcl_fetch.sv
module dcl_fetch
    import dcl_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_fetch,
    input  logic [AW-1:0]        base_addr,
    input  logic                 rd_ack,
    input  logic                 rd_err,
    output logic [AW-1:0]        rd_addr,
    output logic [REC_IDX_W-1:0] word_idx,
    output logic                 word_take,
    output logic                 last_take
);

    localparam int BSH = $clog2(BYTES);

    typedef struct packed {
        logic [REC_IDX_W-1:0] idx;
    } fetch_reg_t;

    fetch_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        word_take = in_fetch && rd_ack && !rd_err;
        last_take = word_take && (r_q.idx == REC_IDX_W'(REC_WORDS - 1));
        if (clear) begin
            r_d.idx = '0;
        end else if (word_take) begin
            r_d.idx = r_q.idx + 1'b1;
        end
        word_idx = r_q.idx;
        rd_addr  = base_addr + (AW'(r_q.idx) << BSH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch && !rd_ack && !clear |=> $stable(rd_addr)); // R2

endmodule

// File: rtl/dcl_src_addr.sv
module dcl_src_addr #(
    parameter int AW    = 32,
    parameter int BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [AW-1:0] wrap_addr,
    input  logic [AW-1:0] wrap_to,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } src_reg_t;

    src_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.addr = load_val;
        end else if (step) begin
            if (r_q.addr == wrap_addr) begin
                r_d.addr = wrap_to;
            end else begin
                r_d.addr = r_q.addr + AW'(BYTES);
            end
        end
        addr = r_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_WRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && (addr == wrap_addr) |=> addr == $past(wrap_to)); // R5

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && (addr != wrap_addr) |=> addr == $past(addr) + AW'(BYTES)); // R5

endmodule

// File: rtl/desc_chain_loader.sv
module desc_chain_loader
    import dcl_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    list_ptr,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_ack,
    input  logic [DW-1:0]    rd_data,
    input  logic             rd_err,
    input  logic             beat,
    output logic [AW-1:0]    xfer_src,
    output logic [AW-1:0]    xfer_dst,
    output logic [LEN_W-1:0] xfer_remaining,
    output logic             xfer_active,
    output logic             xfer_start,
    output logic             list_done,
    output logic             load_err
);

    localparam int BYTES = DW / 8;

    typedef struct packed {
        dcl_state_e       st;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    wrap;
        logic [AW-1:0]    wto;
        logic [AW-1:0]    link;
        logic             stop;
        logic [LEN_W-1:0] rem;
        logic             xstart;
        logic             ldone;
        logic             err;
    } ctl_reg_t;

    ctl_reg_t c_d, c_q;

    logic                 fetch_clear;
    logic                 src_step;
    logic                 src_load;
    logic [REC_IDX_W-1:0] word_idx;
    logic                 word_take;
    logic                 last_take;

    dcl_fetch #(
        .AW    (AW),
        .BYTES (BYTES)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fetch_clear),
        .in_fetch  (c_q.st == ST_FETCH),
        .base_addr (c_q.ptr),
        .rd_ack    (rd_ack),
        .rd_err    (rd_err),
        .rd_addr   (rd_addr),
        .word_idx  (word_idx),
        .word_take (word_take),
        .last_take (last_take)
    );

    assign src_load = word_take && (word_idx == WI_SRC);

    dcl_src_addr #(
        .AW    (AW),
        .BYTES (BYTES)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (src_load),
        .load_val  (rd_data[AW-1:0]),
        .step      (src_step),
        .wrap_addr (c_q.wrap),
        .wrap_to   (c_q.wto),
        .addr      (xfer_src)
    );

    always_comb begin
        c_d         = c_q;
        c_d.xstart  = 1'b0;
        c_d.ldone   = 1'b0;
        fetch_clear = 1'b0;
        src_step    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st      = ST_FETCH;
                    c_d.ptr     = list_ptr;
                    c_d.err     = 1'b0;
                    fetch_clear = 1'b1;
                end
            end
            ST_FETCH: begin
                if (rd_ack && rd_err) begin
                    c_d.err = 1'b1;
                    c_d.st  = ST_IDLE;
                end else if (word_take) begin
                    unique case (word_idx)
                        WI_DST:  c_d.dst  = rd_data[AW-1:0];
                        WI_LEN:  c_d.rem  = rd_data[LEN_W-1:0];
                        WI_WRAP: c_d.wrap = rd_data[AW-1:0];
                        WI_WTO:  c_d.wto  = rd_data[AW-1:0];
                        WI_CTRL: c_d.stop = rd_data[CTRL_STOP_BIT];
                        WI_LINK: c_d.link = rd_data[AW-1:0];
                        default: ;
                    endcase
                    if (last_take) begin
                        c_d.st     = ST_RUN;
                        c_d.xstart = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (c_q.rem == '0) begin
                    c_d.st = ST_NEXT;
                end else if (beat) begin
                    src_step = 1'b1;
                    c_d.rem  = c_q.rem - 1'b1;
                    c_d.dst  = c_q.dst + AW'(BYTES);
                end
            end
            ST_NEXT: begin
                if (c_q.stop) begin
                    c_d.st    = ST_IDLE;
                    c_d.ldone = 1'b1;
                end else begin
                    c_d.st      = ST_FETCH;
                    c_d.ptr     = c_q.link;
                    fetch_clear = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_req         = (c_q.st == ST_FETCH);
    assign xfer_active    = (c_q.st == ST_RUN);
    assign xfer_dst       = c_q.dst;
    assign xfer_remaining = c_q.rem;
    assign xfer_start     = c_q.xstart;
    assign list_done      = c_q.ldone;
    assign load_err       = c_q.err;

    AST_START_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> xfer_active && !rd_req); // R3

    AST_REMAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active && beat && (xfer_remaining != '0)
        |=> (xfer_remaining == $past(xfer_remaining) - 1'b1)
            && (xfer_dst == $past(xfer_dst) + AW'(BYTES))); // R4

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |-> !xfer_active && !rd_req); // R7

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_err |=> load_err && !rd_req && !xfer_active); // R8

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FETCH || c_q.st == ST_RUN) |=> $stable(c_q.ptr)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE) && !start
        |=> $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_remaining)); // R11

endmodule

// File: tb/desc_chain_loader_test.sv
`timescale 1ns/1ps
module desc_chain_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_ptr = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic        rd_err;
    logic        beat = 1'b0;
    logic [31:0] xfer_src, xfer_dst;
    logic [15:0] xfer_remaining;
    logic        xfer_active, xfer_start, list_done, load_err;

    always #2.5 clk = ~clk;

    desc_chain_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .list_ptr(list_ptr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_err(rd_err), .beat(beat), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_remaining(xfer_remaining), .xfer_active(xfer_active),
        .xfer_start(xfer_start), .list_done(list_done), .load_err(load_err)
    );

    // memory model with one-outstanding responder
    logic [31:0] mem [0:255];
    logic [31:0] log_a [0:127];
    int          nlog = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        ack_q = 1'b0, err_q = 1'b0;
    logic [31:0] data_q = '0;

    assign rd_ack  = ack_q;
    assign rd_data = data_q;
    assign rd_err  = err_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (rd_req && !ack_q) begin
            ack_q  <= 1'b1;
            data_q <= mem[rd_addr[9:2]];
            err_q  <= err_en && (rd_addr == err_addr);
            if (nlog < 128) log_a[nlog] <= rd_addr;
            nlog <= nlog + 1;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_rec(logic [31:0] base, logic [31:0] src, logic [31:0] dst,
                             logic [31:0] len, logic [31:0] wrap, logic [31:0] wto,
                             logic [31:0] ctrl, logic [31:0] link);
        mem[base[9:2] + 0] = src;
        mem[base[9:2] + 1] = dst;
        mem[base[9:2] + 2] = len;
        mem[base[9:2] + 3] = wrap;
        mem[base[9:2] + 4] = wto;
        mem[base[9:2] + 5] = ctrl;
        mem[base[9:2] + 6] = link;
        mem[base[9:2] + 7] = 32'hDEAD_0007;
    endtask

    task automatic do_start(logic [31:0] ptr);
        list_ptr = ptr;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic give_beats(int n);
        for (int i = 0; i < n; i++) begin
            beat = 1'b1;
            @(negedge clk);
        end
        beat = 1'b0;
    endtask

    task automatic wait_xstart(string req);
        int n = 0;
        while (!xfer_start && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'b0, xfer_start}, 32'd1);
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!list_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'b0, list_done}, 32'd1);
        check(req, {30'b0, xfer_active, rd_req}, 32'd0);
        @(negedge clk);
        check(req, {31'b0, list_done}, 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] ptr;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic [31:0] wrap;
        logic [31:0] wto;
        logic [31:0] esrc;
        logic [31:0] edst;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'h000, 32'h1000, 32'h3000, 32'd4, 32'h1008, 32'h2000, 32'h2004, 32'h3010},
        '{32'h020, 32'h1000, 32'h4000, 32'd1, 32'h1000, 32'h1800, 32'h1800, 32'h4004},
        '{32'h040, 32'h0500, 32'h6000, 32'd3, 32'h9000, 32'h0100, 32'h050C, 32'h600C},
        '{32'h060, 32'h0700, 32'h7000, 32'd0, 32'h0700, 32'h0900, 32'h0700, 32'h7000},
        '{32'h080, 32'h2000, 32'h8000, 32'd5, 32'h2004, 32'h2000, 32'h2004, 32'h8014}
    };

    initial begin
        int base;
        logic [31:0] s0, d0, r0;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 idle outputs", {27'b0, rd_req, xfer_active, xfer_start, list_done, load_err}, 32'd0);
        check("R1 src", xfer_src, 32'd0);
        check("R1 dst", xfer_dst, 32'd0);
        check("R1 remaining", {16'b0, xfer_remaining}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: single stop-flagged records
        for (int v = 0; v < NV; v++) begin
            write_rec(VECS[v].ptr, VECS[v].src, VECS[v].dst, VECS[v].len,
                      VECS[v].wrap, VECS[v].wto, 32'd1, VECS[v].ptr);
            base = nlog;
            do_start(VECS[v].ptr);
            wait_xstart("R3 start pulse");
            check("R3 active", {31'b0, xfer_active}, 32'd1);
            check("R3 src loaded", xfer_src, VECS[v].src);
            check("R3 dst loaded", xfer_dst, VECS[v].dst);
            check("R3 len loaded", {16'b0, xfer_remaining}, VECS[v].len);
            if (v == 0) begin
                check("R2 word count", nlog - base, 32'd8);
                for (int k = 0; k < 8; k++)
                    check("R2 fetch order", log_a[base + k], VECS[v].ptr + 32'(4 * k));
            end
            give_beats(int'(VECS[v].len));
            if (VECS[v].len == 0) begin
                wait_done("R10 zero length done");
            end else begin
                wait_done("R7 list done");
            end
            check("R5 final src", xfer_src, VECS[v].esrc);
            check("R4 final dst", xfer_dst, VECS[v].edst);
            check("R4 remaining drained", {16'b0, xfer_remaining}, 32'd0);
        end

        // R11: beats while idle
        s0 = xfer_src; d0 = xfer_dst; r0 = {16'b0, xfer_remaining};
        give_beats(3);
        @(negedge clk);
        check("R11 idle src", xfer_src, s0);
        check("R11 idle dst", xfer_dst, d0);
        check("R11 idle remaining", {16'b0, xfer_remaining}, r0);

        // R6: two-record ring walked back to its head, then stopped
        write_rec(32'h100, 32'hA000, 32'hB000, 32'd2, 32'hFFFF_FFF0, 32'h0, 32'd0, 32'h140);
        write_rec(32'h140, 32'hC000, 32'hD000, 32'd1, 32'hFFFF_FFF0, 32'h0, 32'd0, 32'h100);
        do_start(32'h100);
        wait_xstart("R6 first record");
        check("R6 head src", xfer_src, 32'hA000);
        base = nlog;
        give_beats(2);
        @(negedge clk);
        wait_xstart("R6 link followed");
        check("R6 second src", xfer_src, 32'hC000);
        check("R6 link fetch addr", log_a[base], 32'h140);
        check("R6 no done mid ring", {31'b0, list_done}, 32'd0);
        give_beats(1);
        @(negedge clk);
        wait_xstart("R6 ring back");
        check("R6 ring head again", xfer_src, 32'hA000);
        mem[(32'h140 >> 2) + 5] = 32'd1;
        give_beats(2);
        @(negedge clk);
        wait_xstart("R6 second lap");
        check("R6 second lap src", xfer_src, 32'hC000);
        give_beats(1);
        wait_done("R7 ring stopped");

        // R9: trigger during fetch and during run
        write_rec(32'h180, 32'hE000, 32'hF000, 32'd2, 32'hFFFF_FFF0, 32'h0, 32'd1, 32'h180);
        base = nlog;
        do_start(32'h180);
        repeat (3) @(negedge clk);
        do_start(32'h1C0);
        wait_xstart("R9 start during fetch");
        check("R9 record kept", xfer_src, 32'hE000);
        check("R9 fetch count", nlog - base, 32'd8);
        do_start(32'h1C0);
        give_beats(2);
        wait_done("R9 run done");
        repeat (8) @(negedge clk);
        check("R9 no refetch", nlog - base, 32'd8);
        check("R9 idle", {31'b0, xfer_active}, 32'd0);

        // R8: read error in word 3
        write_rec(32'h200, 32'h5000, 32'h5800, 32'd1, 32'hFFFF_FFF0, 32'h0, 32'd1, 32'h200);
        err_en = 1'b1; err_addr = 32'h20C;
        base = nlog;
        begin
            int n = 0;
            do_start(32'h200);
            while (!load_err && n < 60) begin
                @(negedge clk);
                n++;
            end
        end
        check("R8 error flag", {31'b0, load_err}, 32'd1);
        check("R8 aborted", {30'b0, rd_req, xfer_active}, 32'd0);
        repeat (5) @(negedge clk);
        check("R8 reads stopped", nlog - base, 32'd4);
        check("R8 sticky", {31'b0, load_err}, 32'd1);
        err_en = 1'b0;
        do_start(32'h200);
        check("R8 cleared by start", {31'b0, load_err}, 32'd0);
        wait_xstart("R8 restart");
        check("R8 restart src", xfer_src, 32'h5000);
        give_beats(1);
        wait_done("R8 restart done");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule